// File: doc/BRIEF.md
# Fast Ethernet Transmit Line Encoder

This block turns a stream of 4-bit nibbles from a MAC into the three-level line code of a 100 Mb/s twisted-pair link, producing one code bit per clock at the 125 MHz symbol-bit rate. Once every five clocks it samples a nibble together with a frame-enable and an error flag. It chooses a 5-bit code group from them: a data code, an idle group, a start-of-stream or end-of-stream delimiter, or an error group.

The code group is shifted out MSB first. It is then XOR-combined with the output of an 11-bit linear feedback shift register, converted to NRZI, and finally mapped onto a three-level output that steps through 0, +1, 0, -1 on every NRZI transition. The block ends at the digital level value. Analog shaping and drive are handled elsewhere.

Top module: `fe_tx_encoder`

## Requirements
- R1: While `rst_n` is low, `line_lvl` is 0 (2'b00) and `sym_strobe` is high. The scrambler register resets to all ones (11'h7FF). The serializer resets holding the idle group, so the plain bit in the first cycle after reset is 1.
- R2: `sym_strobe` is high on exactly every fifth clock, starting with the first rising edge after reset release. `tx_en`, `tx_er` and `txd` are sampled only on an edge where `sym_strobe` is high. Changes at any other time have no effect.
- R3: Inside a frame, a sampled nibble is sent as its standard 4B/5B data group, for example 0x0 as 11110, 0x5 as 01011, 0xA as 10110 and 0xF as 11101. Each group goes out MSB first over five consecutive clocks.
- R4: Outside a frame, each slot sends the idle group 11111, and `tx_er` is ignored there.
- R5: A slot that samples `tx_en` high outside a frame sends J (11000). The next slot always sends K (10001). Both slots replace the nibble, and `tx_er` is ignored in them.
- R6: The first data-phase slot that samples `tx_en` low sends T (01101). The following slot sends R (00111) whatever the inputs are. The slot after R may start a new frame with J.
- R7: A data-phase slot that samples `tx_en` and `tx_er` both high sends H (00100) in place of the data group.
- R8: Each clock, the keystream bit is s[10] XOR s[8] of the 11-bit register s. The register shifts to {s[9:0], keystream}, and the scrambled bit is the plain bit XOR the keystream. This gives a keystream period of 2047 clocks.
- R9: The NRZI state toggles on each clock whose scrambled bit is 1 and holds its value otherwise.
- R10: `line_lvl` is two's complement (01 = +1, 00 = 0, 11 = -1, never 10). It steps through 0, +1, 0, -1 cyclically on each NRZI toggle and holds otherwise.
- R11: The level after rising edge t reflects the scrambled bit of the cycle before edge t. The group sampled at edge 5m therefore shapes the level changes at edges 5m+1 through 5m+5.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 125 MHz bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_en | input | 1 | Frame enable from the MAC |
| tx_er | input | 1 | Transmit error flag from the MAC |
| txd | input | 4 | Transmit nibble |
| sym_strobe | output | 1 | High in the cycle whose closing edge samples the inputs |
| line_lvl | output | 2 | Three-level line value, two's complement |

## Verification
Two functions can fall in the same cycle: closing a frame and opening the next one. The bench drops `tx_en` for a single slot and raises it again during the R slot. That slot must still send R, with J following only in the next slot.

A second collision comes from raising `tx_er` in the J slot and in idle slots, where it must lose to the delimiter or idle choice. Both cases are judged by unscrambling the observed level transitions back into 5-bit groups and comparing them with the groups the bench expects.

// File: rtl/fe_tx_pkg.sv
package fe_tx_pkg;
  localparam int NIB_W  = 4;
  localparam int SYM_W  = 5;

  typedef logic [SYM_W-1:0] sym_t;
  typedef logic [NIB_W-1:0] nib_t;

  typedef enum logic [1:0] {
    FR_IDLE,
    FR_SECOND,
    FR_DATA,
    FR_CLOSE
  } frame_st_e;

  localparam sym_t GRP_IDLE = 5'b11111;
  localparam sym_t GRP_J    = 5'b11000;
  localparam sym_t GRP_K    = 5'b10001;
  localparam sym_t GRP_T    = 5'b01101;
  localparam sym_t GRP_R    = 5'b00111;
  localparam sym_t GRP_H    = 5'b00100;

  function automatic sym_t nib_to_grp(input nib_t n);
    sym_t g;
    case (n)
      4'h0: g = 5'b11110;
      4'h1: g = 5'b01001;
      4'h2: g = 5'b10100;
      4'h3: g = 5'b10101;
      4'h4: g = 5'b01010;
      4'h5: g = 5'b01011;
      4'h6: g = 5'b01110;
      4'h7: g = 5'b01111;
      4'h8: g = 5'b10010;
      4'h9: g = 5'b10011;
      4'hA: g = 5'b10110;
      4'hB: g = 5'b10111;
      4'hC: g = 5'b11010;
      4'hD: g = 5'b11011;
      4'hE: g = 5'b11100;
      default: g = 5'b11101;
    endcase
    return g;
  endfunction

  function automatic logic [1:0] phase_to_lvl(input logic [1:0] ph);
    logic [1:0] l;
    case (ph)
      2'd1:    l = 2'b01;
      2'd3:    l = 2'b11;
      default: l = 2'b00;
    endcase
    return l;
  endfunction
endpackage

// File: rtl/fe_grp_framer.sv
module fe_grp_framer
  import fe_tx_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic take,
  input  logic tx_en,
  input  logic tx_er,
  input  nib_t txd,
  output sym_t grp
);
  frame_st_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    grp  = GRP_IDLE;
    case (st_q)
      FR_IDLE: begin
        if (tx_en) begin
          grp  = GRP_J;
          st_d = FR_SECOND;
        end
      end
      FR_SECOND: begin
        grp  = GRP_K;
        st_d = FR_DATA;
      end
      FR_DATA: begin
        if (!tx_en) begin
          grp  = GRP_T;
          st_d = FR_CLOSE;
        end else if (tx_er) begin
          grp  = GRP_H;
        end else begin
          grp  = nib_to_grp(txd);
        end
      end
      default: begin
        grp  = GRP_R;
        st_d = FR_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    st_q <= FR_IDLE;
    else if (take) st_q <= st_d;
  end
endmodule

// File: rtl/fe_grp_serializer.sv
module fe_grp_serializer #(
  parameter int GW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [GW-1:0] grp_in,
  output logic          load,
  output logic          plain_bit
);
  localparam int CW = $clog2(GW);
  localparam logic [CW-1:0] LAST = CW'(GW - 1);

  logic [CW-1:0] cnt_q;
  logic [GW-1:0] sh_q;

  assign load      = (cnt_q == '0);
  assign plain_bit = sh_q[GW-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sh_q  <= '1;
    end else if (load) begin
      sh_q  <= grp_in;
      cnt_q <= CW'(1);
    end else begin
      sh_q  <= {sh_q[GW-2:0], 1'b0};
      cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + CW'(1);
    end
  end
endmodule

// File: rtl/fe_scrambler.sv
module fe_scrambler #(
  parameter int          W     = 11,
  parameter int          TAP_A = 10,
  parameter int          TAP_B = 8,
  parameter logic [W-1:0] SEED = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         plain_bit,
  output logic         scr_bit,
  output logic [W-1:0] state
);
  logic ks;

  assign ks      = state[TAP_A] ^ state[TAP_B];
  assign scr_bit = plain_bit ^ ks;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= SEED;
    else        state <= {state[W-2:0], ks};
  end
endmodule

// File: rtl/fe_line_coder.sv
module fe_line_coder
  import fe_tx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scr_bit,
  output logic       nrzi_q,
  output logic [1:0] line_lvl
);
  logic [1:0] phase_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nrzi_q  <= 1'b0;
      phase_q <= 2'd0;
    end else begin
      nrzi_q  <= nrzi_q ^ scr_bit;
      phase_q <= phase_q + {1'b0, scr_bit};
    end
  end

  assign line_lvl = phase_to_lvl(phase_q);
endmodule

// File: rtl/fe_tx_encoder.sv
module fe_tx_encoder
  import fe_tx_pkg::*;
#(
  parameter int           LFSR_W = 11,
  parameter int           TAP_A  = 10,
  parameter int           TAP_B  = 8,
  parameter logic [10:0]  SEED   = 11'h7FF
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tx_en,
  input  logic       tx_er,
  input  logic [3:0] txd,
  output logic       sym_strobe,
  output logic [1:0] line_lvl
);
  sym_t              grp;
  logic              plain_bit;
  logic              scr_bit;
  logic              nrzi_q;
  logic [LFSR_W-1:0] lfsr_state;

  fe_grp_framer u_framer (
    .clk   (clk),
    .rst_n (rst_n),
    .take  (sym_strobe),
    .tx_en (tx_en),
    .tx_er (tx_er),
    .txd   (txd),
    .grp   (grp)
  );

  fe_grp_serializer #(.GW(SYM_W)) u_ser (
    .clk       (clk),
    .rst_n     (rst_n),
    .grp_in    (grp),
    .load      (sym_strobe),
    .plain_bit (plain_bit)
  );

  fe_scrambler #(
    .W(LFSR_W), .TAP_A(TAP_A), .TAP_B(TAP_B), .SEED(LFSR_W'(SEED))
  ) u_scr (
    .clk       (clk),
    .rst_n     (rst_n),
    .plain_bit (plain_bit),
    .scr_bit   (scr_bit),
    .state     (lfsr_state)
  );

  fe_line_coder u_line (
    .clk      (clk),
    .rst_n    (rst_n),
    .scr_bit  (scr_bit),
    .nrzi_q   (nrzi_q),
    .line_lvl (line_lvl)
  );
endmodule

// File: rtl/fe_tx_checker.sv
module fe_tx_checker #(
  parameter int GW = 5,
  parameter int LW = 11
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sym_strobe,
  input logic [1:0]    line_lvl,
  input logic          nrzi_q,
  input logic          scr_bit,
  input logic [LW-1:0] lfsr_state
);
  logic [3:0] gap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          gap_q <= 4'(GW - 1);
    else if (sym_strobe) gap_q <= '0;
    else                 gap_q <= gap_q + 4'd1;
  end

  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_n |-> (line_lvl == 2'b00 && sym_strobe));

  p_strobe_period_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sym_strobe == (gap_q == 4'(GW - 1)));

  p_lfsr_alive_r8: assert property (@(posedge clk) disable iff (!rst_n)
    lfsr_state != '0);

  p_nrzi_toggle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    scr_bit |=> (nrzi_q != $past(nrzi_q)));

  p_nrzi_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !scr_bit |=> $stable(nrzi_q));

  p_lvl_legal_r10: assert property (@(posedge clk) disable iff (!rst_n)
    line_lvl != 2'b10);

  p_lvl_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (nrzi_q != $past(nrzi_q)) |-> (line_lvl != $past(line_lvl)));

  p_lvl_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(nrzi_q) |-> $stable(line_lvl));

  p_lvl_via_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(line_lvl) != 2'b00 && !$stable(line_lvl)) |-> line_lvl == 2'b00);
endmodule

bind fe_tx_encoder fe_tx_checker #(.GW(5), .LW(11)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .sym_strobe (sym_strobe),
  .line_lvl   (line_lvl),
  .nrzi_q     (nrzi_q),
  .scr_bit    (scr_bit),
  .lfsr_state (lfsr_state)
);

// File: tb/sim_fe_tx_encoder.sv
`timescale 1ns/1ps
module sim_fe_tx_encoder;
  localparam int CLK_PERIOD = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tx_en = 1'b0;
  logic       tx_er = 1'b0;
  logic [3:0] txd = 4'h0;
  logic       sym_strobe;
  logic [1:0] line_lvl;

  always #(CLK_PERIOD/2) clk = ~clk;

  fe_tx_encoder u0 (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .tx_er(tx_er), .txd(txd),
    .sym_strobe(sym_strobe), .line_lvl(line_lvl)
  );

  int n_chk = 0;
  int n_fail = 0;

  // R3 code groups in decimal, indexed by nibble value
  int code_tbl[16] = '{30, 9, 20, 21, 10, 11, 14, 15, 18, 19, 22, 23, 26, 27, 28, 29};

  bit [10:0] ref_sr = 11'h7FF;
  int  edges = 0;
  int  mode = 0;
  int  bitq[$];
  int  expq[$];
  string tagq[$];
  int  cur_plain = 1;
  int  ph = 0;
  int  prev_lvl = 0;
  int  last_ks = 0;
  int  rec_val = 0;
  int  rec_n = 0;
  bit  rec_on = 0;
  int  trans_q[$];

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int lvl_of(int p);
    if (p == 1) return 1;
    if (p == 3) return -1;
    return 0;
  endfunction

  task automatic pick_group();
    int g;
    string t;
    if (mode == 0) begin
      if (tx_en) begin g = 24; t = "R5 J"; mode = 1; end
      else       begin g = 31; t = "R4 idle"; end
    end else if (mode == 1) begin
      g = 17; t = "R5 K"; mode = 2;
    end else if (mode == 2) begin
      if (!tx_en)     begin g = 13; t = "R6 T"; mode = 3; end
      else if (tx_er) begin g = 4;  t = "R7 H"; end
      else            begin g = code_tbl[txd]; t = "R3 data"; end
    end else begin
      g = 7; t = "R6 R"; mode = 0;
    end
    for (int i = 4; i >= 0; i--) bitq.push_back((g >> i) & 1);
    expq.push_back(g);
    tagq.push_back(t);
  endtask

  task automatic tick();
    int ks, sb, act, chg, rb;
    @(posedge clk);
    ks = ref_sr[10] ^ ref_sr[8];
    sb = cur_plain ^ ks;
    if (sb == 1) ph = (ph + 1) % 4;
    ref_sr = {ref_sr[9:0], ks[0]};
    last_ks = ks;
    if (edges % 5 == 0) pick_group();
    cur_plain = bitq.pop_front();
    edges++;
    @(negedge clk);
    act = int'($signed(line_lvl));
    check("R10 R11 level vs model", act, lvl_of(ph));
    check("R2 strobe", int'(sym_strobe), int'(edges % 5 == 0));
    chg = (act != prev_lvl) ? 1 : 0;
    prev_lvl = act;
    if (rec_on) trans_q.push_back(chg);
    if (edges >= 2) begin
      rb = chg ^ last_ks;
      rec_val = (rec_val << 1) | rb;
      rec_n++;
      if (rec_n == 5) begin
        check({tagq.pop_front(), " recovered group"}, rec_val, expq.pop_front());
        rec_val = 0;
        rec_n = 0;
      end
    end
  endtask

  task automatic slot(bit en, bit er, logic [3:0] d);
    tx_en = en; tx_er = er; txd = d;
    tick();
    tx_en = ~en; tx_er = ~er; txd = ~d;
    for (int i = 0; i < 4; i++) tick();
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", edges, 0);
    finish_run();
  end

  initial begin
    int mism0, mism1;
    repeat (3) @(negedge clk);
    check("R1 reset level", int'($signed(line_lvl)), 0);
    check("R1 reset strobe", int'(sym_strobe), 1);
    rst_n = 1'b1;

    // R4: idle, tx_er ignored outside a frame
    slot(0, 0, 4'h0);
    slot(0, 1, 4'h3);
    slot(0, 1, 4'hF);
    // R5: frame start, tx_er in J slot ignored
    slot(1, 1, 4'h5);
    slot(1, 0, 4'h5);
    // R3: every data nibble
    for (int n = 0; n < 16; n++) slot(1, 0, 4'(n));
    // R7: error group
    slot(1, 1, 4'hA);
    slot(1, 0, 4'hA);
    // R6: close, tx_en high again during R slot, then new frame
    slot(0, 0, 4'h0);
    slot(1, 1, 4'h7);
    slot(1, 0, 4'h5);
    slot(1, 0, 4'hD);
    slot(1, 0, 4'h2);
    slot(0, 1, 4'h0);
    slot(0, 0, 4'h0);
    // R8: long idle, keystream period
    for (int s = 0; s < 20; s++) slot(0, 0, 4'h0);
    rec_on = 1;
    for (int s = 0; s < 440; s++) slot(0, 0, 4'h0);
    rec_on = 0;
    mism0 = 0;
    mism1 = 0;
    for (int i = 0; i < 100; i++) begin
      if (trans_q[i] != trans_q[i + 2047]) mism0++;
      if (trans_q[i] != trans_q[i + 2046]) mism1++;
    end
    check("R8 period 2047 mismatches", mism0, 0);
    check("R8 not period 2046", int'(mism1 > 0), 1);
    finish_run();
  end
endmodule